// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This datapath takes a vector of 32-bit accumulator lanes and two byte vectors of the same total width. For every lane it forms four byte-by-byte products, adds them to that lane's accumulator value and returns the packed 32-bit results. A three-bit mode chooses how the bytes are extended before they are multiplied (both signed, signed A with unsigned B, or both unsigned). It also chooses whether the lane sum wraps or is clamped. A width input chooses between the full vector and its lower half.

The block samples operands, mode and width together on a cycle where `valid_i` is high. One cycle later it presents the registered result with `valid_o`. Products are kept at full precision and every lane sum is formed in 35 bits before any clamp, so the clamp decision never sees a truncated value.

Top module: `dpacc_top`

## Requirements
- R1: Output lane j is built from bytes 4j, 4j+1, 4j+2 and 4j+3 of A and B (byte n at bits 8n+7:8n), each A byte paired with the B byte of the same index, plus lane j of W (bits 32j+31:32j).
- R2: With mode[1:0] = 00, both bytes of a pair are sign-extended before they are multiplied.
- R3: With mode[1:0] = 01, A bytes are sign-extended, B bytes are zero-extended, and the product is signed.
- R4: With mode[1:0] = 10, both bytes are zero-extended before they are multiplied.
- R5: With mode[2] = 0 the lane result is the exact sum modulo 2^32.
- R6: With mode[2] = 1 and mode[1:0] of 00 or 01, the lane sum (W read as signed) is clamped to [-2^31, 2^31-1].
- R7: With mode[2] = 1 and both operands unsigned, W is read as unsigned and the sum is clamped to [0, 2^32-1].
- R8: When `wide_i` is 0, only the lower LANES/2 lanes are computed and every result bit above them is zero.
- R9: `valid_o` is high exactly one cycle after `valid_i` was high. `res_o` updates only on such a cycle and holds otherwise.
- R10: A synchronous active-high reset clears `valid_o` and `res_o` to zero.
- R11: mode[1:0] = 11 behaves exactly like 10 (both unsigned), including the unsigned clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands, mode and width are valid this cycle |
| mode_i | input | 3 | [1:0] operand signedness, [2] saturate |
| wide_i | input | 1 | 1: all lanes, 0: lower half only |
| w_i | input | 32*LANES | Accumulator lanes |
| a_i | input | 32*LANES | First byte vector |
| b_i | input | 32*LANES | Second byte vector |
| valid_o | output | 1 | Result valid |
| res_o | output | 32*LANES | Packed 32-bit lane results |

## Verification
A table of patterns is applied with the same 32-bit word in every lane. Bytes of 0xFF, 0x80 and 0x7F tell the three extension rules apart, because the same bits give -1, 255 or mixed products depending on the mode. Accumulators near both 32-bit limits, paired with the largest positive and negative products, separate wrapping from signed and unsigned clamping. A large unsigned W in unsigned saturating mode shows that W is not read as negative. Directed vectors with a different value in every byte show the lane grouping. The same data with the narrow width shows the upper lanes are zeroed. An idle cycle with new data shows the output holds.

// File: rtl/dpacc_pkg.sv
package dpacc_pkg;
  localparam int BYTE_W = 8;
  localparam int LANE_W = 32;
  localparam int GRP    = LANE_W / BYTE_W;
  localparam int EXT_W  = BYTE_W + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int SUM_W  = LANE_W + 3;

  typedef enum logic [1:0] {
    SG_SS  = 2'b00,
    SG_SU  = 2'b01,
    SG_UU  = 2'b10,
    SG_UU2 = 2'b11
  } sign_sel_e;

  typedef struct packed {
    logic      sat;
    sign_sel_e sel;
  } mode_t;
endpackage

// File: rtl/dpacc_mul.sv
module dpacc_mul
  import dpacc_pkg::*;
(
  input  logic [BYTE_W-1:0]        a_byte,
  input  logic [BYTE_W-1:0]        b_byte,
  input  logic                     a_sgn,
  input  logic                     b_sgn,
  output logic signed [PROD_W-1:0] prod
);
  logic [EXT_W-1:0] ax, bx;
  logic signed [PROD_W-1:0] ae, be;

  assign ax = {a_sgn & a_byte[BYTE_W-1], a_byte};
  assign bx = {b_sgn & b_byte[BYTE_W-1], b_byte};
  assign ae = {{(PROD_W-EXT_W){ax[EXT_W-1]}}, ax};
  assign be = {{(PROD_W-EXT_W){bx[EXT_W-1]}}, bx};
  assign prod = ae * be;
endmodule

// File: rtl/dpacc_lane.sv
module dpacc_lane
  import dpacc_pkg::*;
(
  input  logic [LANE_W-1:0] a_grp,
  input  logic [LANE_W-1:0] b_grp,
  input  logic [LANE_W-1:0] w_lane,
  input  logic              a_sgn,
  input  logic              b_sgn,
  input  logic              w_uns,
  input  logic              sat,
  input  logic              sat_uns,
  output logic [LANE_W-1:0] res
);
  localparam logic signed [SUM_W-1:0] S_MAX =
    {{(SUM_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] S_MIN =
    {{(SUM_W-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] U_MAX =
    {{(SUM_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

  logic signed [PROD_W-1:0] prods [GRP];
  logic signed [SUM_W-1:0]  total;

  for (genvar k = 0; k < GRP; k++) begin : g_mul
    dpacc_mul u_mul (
      .a_byte (a_grp[k*BYTE_W +: BYTE_W]),
      .b_byte (b_grp[k*BYTE_W +: BYTE_W]),
      .a_sgn  (a_sgn),
      .b_sgn  (b_sgn),
      .prod   (prods[k])
    );
  end

  always_comb begin
    total = {{(SUM_W-LANE_W){w_lane[LANE_W-1] & ~w_uns}}, w_lane};
    for (int k = 0; k < GRP; k++) begin
      total = total + {{(SUM_W-PROD_W){prods[k][PROD_W-1]}}, prods[k]};
    end
  end

  always_comb begin
    res = total[LANE_W-1:0];
    if (sat) begin
      if (sat_uns) begin
        if (total < 0)          res = '0;
        else if (total > U_MAX) res = '1;
      end else begin
        if (total > S_MAX)      res = S_MAX[LANE_W-1:0];
        else if (total < S_MIN) res = S_MIN[LANE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dpacc_top.sv
module dpacc_top
  import dpacc_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_i,
  input  logic [2:0]              mode_i,
  input  logic                    wide_i,
  input  logic [LANES*LANE_W-1:0] w_i,
  input  logic [LANES*LANE_W-1:0] a_i,
  input  logic [LANES*LANE_W-1:0] b_i,
  output logic                    valid_o,
  output logic [LANES*LANE_W-1:0] res_o
);
  localparam int HALF = LANES / 2;
  localparam int VW   = LANES * LANE_W;

  mode_t mode;
  logic  a_sgn, b_sgn, uu, w_uns;
  logic [VW-1:0] nxt;

  assign mode  = mode_t'(mode_i);
  assign a_sgn = (mode.sel == SG_SS) || (mode.sel == SG_SU);
  assign b_sgn = (mode.sel == SG_SS);
  assign uu    = ~a_sgn;
  assign w_uns = mode.sat & uu;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] lane_res;
    dpacc_lane u_lane (
      .a_grp   (a_i[j*LANE_W +: LANE_W]),
      .b_grp   (b_i[j*LANE_W +: LANE_W]),
      .w_lane  (w_i[j*LANE_W +: LANE_W]),
      .a_sgn   (a_sgn),
      .b_sgn   (b_sgn),
      .w_uns   (w_uns),
      .sat     (mode.sat),
      .sat_uns (uu),
      .res     (lane_res)
    );
    if (j >= HALF) begin : g_upper
      assign nxt[j*LANE_W +: LANE_W] = wide_i ? lane_res : '0;
    end else begin : g_lower
      assign nxt[j*LANE_W +: LANE_W] = lane_res;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= nxt;
    end
  end
endmodule

// File: rtl/dpacc_chk.sv
module dpacc_chk #(
  parameter int LANES = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                valid_i,
  input logic [2:0]          mode_i,
  input logic                wide_i,
  input logic [LANES*32-1:0] w_i,
  input logic                valid_o,
  input logic [LANES*32-1:0] res_o
);
  localparam int HB = LANES * 16;

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  // R9
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(res_o));

  // R8
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !wide_i) |=> (res_o[LANES*32-1:HB] == '0));

  // R7
  uu_sat_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && mode_i == 3'b110 && w_i[31:0] == 32'hFFFF_FFFF)
      |=> (res_o[31:0] == 32'hFFFF_FFFF));
endmodule

bind dpacc_top dpacc_chk #(.LANES(LANES)) u_dpacc_chk (
  .clk     (clk),
  .rst     (rst),
  .valid_i (valid_i),
  .mode_i  (mode_i),
  .wide_i  (wide_i),
  .w_i     (w_i),
  .valid_o (valid_o),
  .res_o   (res_o)
);

// File: tb/test_dpacc_top.sv
module test_dpacc_top;
  localparam int LANES = 8;
  localparam int VW    = LANES * 32;
  localparam int NV    = 16;

  typedef struct packed {
    logic [2:0]  mode;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] w;
    logic [31:0] exp;
  } vec_t;

  // mode: [1:0] 00 SS, 01 SU, 10 UU, 11 UU; [2] saturate
  localparam vec_t TBL [NV] = '{
    '{3'b000, 32'h01020304, 32'h01010101, 32'h0000000A, 32'h00000014}, // R2
    '{3'b000, 32'hFFFFFFFF, 32'h02020202, 32'h00000000, 32'hFFFFFFF8}, // R2
    '{3'b001, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFC04}, // R3
    '{3'b010, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h0003F804}, // R4
    '{3'b000, 32'h80808080, 32'h80808080, 32'h00000000, 32'h00010000}, // R2
    '{3'b000, 32'h7F7F7F7F, 32'h7F7F7F7F, 32'h7FFFFFFF, 32'h8000FC03}, // R5
    '{3'b100, 32'h7F7F7F7F, 32'h7F7F7F7F, 32'h7FFFFFFF, 32'h7FFFFFFF}, // R6
    '{3'b100, 32'h80808080, 32'h7F7F7F7F, 32'h80000000, 32'h80000000}, // R6
    '{3'b101, 32'h80808080, 32'hFFFFFFFF, 32'h80000000, 32'h80000000}, // R6
    '{3'b101, 32'h7F7F7F7F, 32'hFFFFFFFF, 32'h7FFF0000, 32'h7FFFFFFF}, // R6
    '{3'b110, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFF0000, 32'hFFFFFFFF}, // R7
    '{3'b110, 32'h01010101, 32'h01010101, 32'hF0000000, 32'hF0000004}, // R7
    '{3'b010, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFF0000, 32'h0002F804}, // R5
    '{3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h0003F804}, // R11
    '{3'b100, 32'h01020304, 32'hFFFFFFFF, 32'h00000005, 32'hFFFFFFFB}, // R6
    '{3'b001, 32'h01010101, 32'h80808080, 32'h00000000, 32'h00000200}  // R3
  };
  localparam string TAG [NV] = '{"R2","R2","R3","R4","R2","R5","R6","R6",
                                 "R6","R6","R7","R7","R5","R11","R6","R3"};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic [2:0]    mode_i = '0;
  logic          wide_i = 1'b1;
  logic [VW-1:0] w_i = '0, a_i = '0, b_i = '0;
  logic          valid_o;
  logic [VW-1:0] res_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dpacc_top #(.LANES(LANES)) i_dpacc_top (
    .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i), .wide_i(wide_i),
    .w_i(w_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o)
  );

  function automatic logic [31:0] ref_lane(input logic [2:0] md,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] w);
    longint s, av, bv;
    logic uu;
    uu = md[1];
    s = (uu && md[2]) ? longint'({32'h0, w}) : longint'($signed(w));
    for (int k = 0; k < 4; k++) begin
      av = uu ? longint'({56'h0, a[8*k +: 8]}) : longint'($signed(a[8*k +: 8]));
      bv = (md[1:0] == 2'b00) ? longint'($signed(b[8*k +: 8]))
                              : longint'({56'h0, b[8*k +: 8]});
      s = s + av * bv;
    end
    if (md[2]) begin
      if (uu) begin
        if (s < 0) s = 0;
        if (s > 64'sd4294967295) s = 64'sd4294967295;
      end else begin
        if (s > 64'sd2147483647) s = 64'sd2147483647;
        if (s < -64'sd2147483648) s = -64'sd2147483648;
      end
    end
    return s[31:0];
  endfunction

  task automatic check(input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [2:0] md, input logic wd,
                      input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [VW-1:0] w);
    @(negedge clk);
    mode_i = md; wide_i = wd; a_i = a; b_i = b; w_i = w; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    logic [VW-1:0] av, bv, wv, ev, held;
    repeat (3) @(negedge clk);
    // R10: reset clears outputs
    check("R10", {{(VW-1){1'b0}}, valid_o}, '0);
    check("R10", res_o, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      av = {LANES{TBL[i].a}}; bv = {LANES{TBL[i].b}};
      wv = {LANES{TBL[i].w}}; ev = {LANES{TBL[i].exp}};
      fire(TBL[i].mode, 1'b1, av, bv, wv);
      check(TAG[i], res_o, ev);
    end

    // R1: distinct bytes in every position
    for (int n = 0; n < VW / 8; n++) begin
      av[8*n +: 8] = 8'(n * 7 + 3);
      bv[8*n +: 8] = 8'(n * 13 + 200);
    end
    for (int j = 0; j < LANES; j++) wv[32*j +: 32] = 32'h100 * (j + 1);
    for (int md = 0; md < 3; md++) begin
      for (int j = 0; j < LANES; j++)
        ev[32*j +: 32] = ref_lane(3'(md), av[32*j +: 32], bv[32*j +: 32], wv[32*j +: 32]);
      fire(3'(md), 1'b1, av, bv, wv);
      check("R1", res_o, ev);
    end

    // R9: one-cycle latency
    @(negedge clk);
    mode_i = 3'b000; wide_i = 1'b1; valid_i = 1'b1;
    @(negedge clk);
    check("R9", {{(VW-1){1'b0}}, valid_o}, {{(VW-1){1'b0}}, 1'b1});
    valid_i = 1'b0;
    @(negedge clk);
    check("R9", {{(VW-1){1'b0}}, valid_o}, '0);

    // R8: narrow width zeroes upper half
    for (int j = 0; j < LANES; j++)
      ev[32*j +: 32] = (j < LANES / 2) ?
        ref_lane(3'b010, av[32*j +: 32], bv[32*j +: 32], wv[32*j +: 32]) : 32'h0;
    fire(3'b010, 1'b0, av, bv, wv);
    check("R8", res_o, ev);
    held = res_o;

    // R9: new data without valid is ignored
    @(negedge clk);
    a_i = '1; b_i = '1; w_i = '1; mode_i = 3'b000; wide_i = 1'b1;
    @(negedge clk);
    check("R9", res_o, held);

    // R10: reset mid-run clears result
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10", res_o, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule